// File: doc/BRIEF.md
# Split-Read 64-bit Cycle Counter

This block keeps a free-running cycle count of twice the data-word width (64 bits by default). Software sees it through a small register window of three consecutive addresses: a control word at the base address, the lower half of the count one above it, and the upper half one above that. The count advances by one on every clock while the enable bit in the control word is set. Reads return data one clock after the request, through a registered read port.

The block does not freeze the upper half when the lower half is read. Instead, a small tracker watches the order of accesses. It marks a read pair as torn when either of two things happens between the lower-half read and the upper-half read: the lower half rolls over into the upper half, or an interrupt is taken. Bit 31 of the control word reports whether the last pair was clean. Software reads lower, then upper, then control, and repeats the sequence until bit 31 comes back set.

Top module: `split_read_counter64`

## Requirements
- R1: After synchronous reset, the count, the enable and the pair status are all zero, so control, lower and upper reads all return 0.
- R2: A write to the control address (base+0) loads the enable from wdata bit 0. Control reads return the enable in bit 0. While the enable is 0, the count holds its value.
- R3: While enabled, the count rises by exactly one per clock. A read issued in cycle t returns, in rdata after edge t, the lower half (base+1) or upper half (base+2) of the count as it stood before edge t, zero-extended.
- R4: Writes to the lower or upper address do not change the count.
- R5: A lower read followed later by an upper read sets control bit 31 to 1 when no interrupt and no rollover fell in the window.
- R6: If irq_taken is high in any cycle from the lower read up to and including the upper read, the upper read sets control bit 31 to 0.
- R7: If the lower half carries into the upper half at the lower-read edge or at any later edge before the upper read, bit 31 becomes 0. A carry at the upper-read edge itself does not tear the pair.
- R8: An upper read that no lower read has armed clears bit 31 to 0. This covers a second upper read after a completed pair.
- R9: Bit 31 changes only on upper reads. Control reads, lower reads and interrupts outside a pair leave it unchanged.
- R10: A new lower read restarts the window and discards any tear seen before it.
- R11: A read of any address outside the three-word window returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read request for addr this cycle |
| wr_en | input | 1 | Write request for addr this cycle |
| addr | input | ADDR_W (12) | Register address |
| wdata | input | DATA_W (32) | Write data |
| irq_taken | input | 1 | High in a cycle in which the processor takes an interrupt or exception |
| rdata | output | DATA_W (32) | Registered read data, valid the cycle after rd_en |

## Verification
The bench builds the block with a 16-bit count, so the lower half rolls over every 256 clocks. This lets it place pairs exactly around the rollover.

- A lower read taken while the low byte is 0xFF must be marked torn. A design that sampled the carry one cycle late would wrongly report it clean.
- A pair whose upper read lands on the rollover edge must be reported clean. A design that also counted that edge would reject a consistent snapshot.
- An interrupt on the upper-read cycle must tear the pair.
- A repeated upper read must report a tear. A design that failed to disarm the tracker after a pair would accept stale halves.
- A new lower read after an interrupt must start from a clean window. A design that never reset its flag would make software retry forever.

// File: rtl/srd_pkg.sv
package srd_pkg;
  typedef enum logic [1:0] {
    TRK_IDLE = 2'd0,
    TRK_LOW  = 2'd1,
    TRK_PAIR = 2'd2
  } trk_state_e;

  // Word offsets from the window base; the order is fixed by the access protocol
  localparam int OFS_CTRL = 0;
  localparam int OFS_LO   = 1;
  localparam int OFS_HI   = 2;
endpackage

// File: rtl/srd_counter.sv
module srd_counter #(
  parameter int HALF_W = 32,
  localparam int CNT_W = 2 * HALF_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_wr,
  input  logic             en_val,
  output logic             en_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             lo_carry
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else begin
      if (en_q)  cnt_q <= cnt_q + 1'b1;
      if (en_wr) en_q  <= en_val;
    end
  end

  // The upper half changes at this edge exactly when the lower half is all ones
  assign lo_carry = en_q & (&cnt_q[HALF_W-1:0]);
endmodule

// File: rtl/srd_tracker.sv
module srd_tracker
  import srd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       rd_lo,
  input  logic       rd_hi,
  input  logic       irq_taken,
  input  logic       lo_carry,
  output logic       status_q,
  output trk_state_e state_q
);
  logic torn_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= TRK_IDLE;
      torn_q   <= 1'b0;
      status_q <= 1'b0;
    end else if (rd_lo) begin
      // A fresh lower read opens a new window; the carry at this very edge counts
      state_q <= TRK_LOW;
      torn_q  <= irq_taken | lo_carry;
    end else if (rd_hi) begin
      torn_q <= 1'b0;
      if (state_q == TRK_LOW) begin
        status_q <= ~(torn_q | irq_taken);
        state_q  <= TRK_PAIR;
      end else begin
        status_q <= 1'b0;
        state_q  <= TRK_IDLE;
      end
    end else if (state_q == TRK_LOW) begin
      torn_q <= torn_q | irq_taken | lo_carry;
    end
  end
endmodule

// File: rtl/split_read_counter64.sv
module split_read_counter64
  import srd_pkg::*;
#(
  parameter int              ADDR_W = 12,
  parameter logic [ADDR_W-1:0] BASE = 'h103,
  parameter int              DATA_W = 32,
  parameter int              HALF_W = 32,
  localparam int             CNT_W  = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              irq_taken,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [ADDR_W-1:0] A_CTRL = BASE + ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_LO   = BASE + ADDR_W'(OFS_LO);
  localparam logic [ADDR_W-1:0] A_HI   = BASE + ADDR_W'(OFS_HI);

  logic             sel_ctrl, sel_lo, sel_hi;
  logic             en_q, lo_carry, status_q;
  logic [CNT_W-1:0] cnt_q;
  trk_state_e       trk_state;
  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-1:0] rdata_q;
  logic             unused_wbits;

  assign sel_ctrl = (addr == A_CTRL);
  assign sel_lo   = (addr == A_LO);
  assign sel_hi   = (addr == A_HI);
  assign unused_wbits = ^wdata[DATA_W-1:1];

  srd_counter #(.HALF_W(HALF_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .en_wr    (wr_en & sel_ctrl),
    .en_val   (wdata[0]),
    .en_q     (en_q),
    .cnt_q    (cnt_q),
    .lo_carry (lo_carry)
  );

  srd_tracker u_trk (
    .clk       (clk),
    .rst       (rst),
    .rd_lo     (rd_en & sel_lo),
    .rd_hi     (rd_en & sel_hi),
    .irq_taken (irq_taken),
    .lo_carry  (lo_carry),
    .status_q  (status_q),
    .state_q   (trk_state)
  );

  always_comb begin
    rd_word = '0;
    if (sel_ctrl) begin
      rd_word[DATA_W-1] = status_q;
      rd_word[0]        = en_q;
    end else if (sel_lo) begin
      rd_word[HALF_W-1:0] = cnt_q[HALF_W-1:0];
    end else if (sel_hi) begin
      rd_word[HALF_W-1:0] = cnt_q[CNT_W-1:HALF_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_word;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/split_read_counter64_chk.sv
module split_read_counter64_chk
  import srd_pkg::*;
#(
  parameter int              ADDR_W = 12,
  parameter logic [ADDR_W-1:0] BASE = 'h103,
  parameter int              DATA_W = 32,
  parameter int              HALF_W = 32,
  localparam int             CNT_W  = 2 * HALF_W
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              irq_taken,
  input logic [DATA_W-1:0] rdata,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              en_q,
  input logic              status_q,
  input trk_state_e        st
);
  localparam logic [ADDR_W-1:0] A_CTRL = BASE + ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_LO   = BASE + ADDR_W'(OFS_LO);
  localparam logic [ADDR_W-1:0] A_HI   = BASE + ADDR_W'(OFS_HI);

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cnt_q == '0 && !en_q && !status_q && rdata == '0));

  // R2
  enable_load_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_CTRL) |=> (en_q == $past(wdata[0])));

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    en_q |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> $stable(cnt_q));

  // R6
  irq_tear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == A_HI && irq_taken) |=> !status_q);

  // R8
  orphan_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == A_HI && st != TRK_LOW) |=> !status_q);

  // R9
  status_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && addr == A_HI) |=> $stable(status_q));

  // R11
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr != A_CTRL && addr != A_LO && addr != A_HI) |=> (rdata == '0));
endmodule

bind split_read_counter64 split_read_counter64_chk #(
  .ADDR_W(ADDR_W), .BASE(BASE), .DATA_W(DATA_W), .HALF_W(HALF_W)
) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .irq_taken(irq_taken), .rdata(rdata), .cnt_q(cnt_q),
  .en_q(en_q), .status_q(status_q), .st(trk_state)
);

// File: tb/split_read_counter64_test.sv
`timescale 1ns/1ps
module split_read_counter64_test;
  localparam int HW = 8;
  localparam logic [11:0] A_CTRL = 12'h103;
  localparam logic [11:0] A_LO   = 12'h104;
  localparam logic [11:0] A_HI   = 12'h105;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_en = 1'b0, wr_en = 1'b0, irq_taken = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  // reference model state
  logic [2*HW-1:0] m_cnt;
  logic            m_en, m_torn, m_status;
  int              m_state;   // 0 idle, 1 lower read seen, 2 pair done

  always #2.5 clk = ~clk;

  split_read_counter64 #(.ADDR_W(12), .BASE(12'h103), .DATA_W(32), .HALF_W(HW)) uut (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .irq_taken(irq_taken), .rdata(rdata)
  );

  function automatic logic [31:0] model_read(input logic [11:0] a);
    case (a)
      A_CTRL:  return {m_status, 30'b0, m_en};
      A_LO:    return {24'b0, m_cnt[HW-1:0]};
      A_HI:    return {24'b0, m_cnt[2*HW-1:HW]};
      default: return 32'b0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: rdata=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit rd, input bit wr, input logic [11:0] a,
                     input logic [31:0] wd, input bit irq, input string req);
    logic [31:0] expv;
    bit carry;
    @(negedge clk);
    rd_en = rd; wr_en = wr; addr = a; wdata = wd; irq_taken = irq;
    carry = m_en && (m_cnt[HW-1:0] == '1);
    expv  = model_read(a);
    if (rd && a == A_LO) begin
      m_state = 1; m_torn = irq | carry;
    end else if (rd && a == A_HI) begin
      if (m_state == 1) begin m_status = !(m_torn | irq); m_state = 2; end
      else begin m_status = 1'b0; m_state = 0; end
      m_torn = 1'b0;
    end else if (m_state == 1) begin
      m_torn = m_torn | irq | carry;
    end
    if (m_en) m_cnt = m_cnt + 1'b1;
    if (wr && a == A_CTRL) m_en = wd[0];
    @(posedge clk); #1;
    if (rd) check(req, rdata, expv);
  endtask

  task automatic idle(input int n, input bit irq);
    for (int i = 0; i < n; i++) cyc(0, 0, 12'h000, 32'h0, irq, "");
  endtask

  task automatic wait_lo(input logic [HW-1:0] v);
    while (m_cnt[HW-1:0] != v) idle(1, 0);
  endtask

  task automatic expect_status(input bit s, input string req);
    vectors++;
    if (m_status !== s) begin
      miscompares++;
      $display("FAIL %s: model status=%0b expected=%0b", req, m_status, s);
    end
    cyc(1, 0, A_CTRL, 32'h0, 0, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    m_cnt = '0; m_en = 0; m_torn = 0; m_status = 0; m_state = 0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1: reset state
    cyc(1, 0, A_CTRL, 0, 0, "R1");
    cyc(1, 0, A_LO,   0, 0, "R1");
    cyc(1, 0, A_HI,   0, 0, "R1");

    // R4: writes to the count halves are dropped
    cyc(0, 1, A_LO, 32'hFFFF_FFFF, 0, "R4");
    cyc(0, 1, A_HI, 32'hFFFF_FFFF, 0, "R4");
    cyc(1, 0, A_LO, 0, 0, "R4");
    cyc(1, 0, A_HI, 0, 0, "R4");

    // R2/R3: enable and counting
    cyc(0, 1, A_CTRL, 32'h1, 0, "R2");
    cyc(1, 0, A_CTRL, 0, 0, "R2");
    cyc(1, 0, A_LO, 0, 0, "R3");
    idle(5, 0);
    cyc(1, 0, A_LO, 0, 0, "R3");
    cyc(0, 1, A_LO, 32'h0, 0, "R4");
    cyc(1, 0, A_LO, 0, 0, "R4");

    // R5: clean pair
    wait_lo(8'h10);
    cyc(1, 0, A_LO, 0, 0, "R5"); idle(2, 0);
    cyc(1, 0, A_HI, 0, 0, "R5");
    expect_status(1, "R5");

    // R6: interrupt in gap, then on the upper-read cycle; software retry loop
    cyc(1, 0, A_LO, 0, 0, "R6"); idle(1, 1);
    cyc(1, 0, A_HI, 0, 0, "R6");
    expect_status(0, "R6");
    cyc(1, 0, A_LO, 0, 0, "R6");
    cyc(1, 0, A_HI, 0, 1, "R6");
    expect_status(0, "R6");
    cyc(1, 0, A_LO, 0, 0, "R6");
    cyc(1, 0, A_HI, 0, 0, "R6");
    expect_status(1, "R6");

    // R10: a new lower read discards an earlier tear
    cyc(1, 0, A_LO, 0, 1, "R10"); idle(1, 1);
    cyc(1, 0, A_LO, 0, 0, "R10");
    cyc(1, 0, A_HI, 0, 0, "R10");
    expect_status(1, "R10");

    // R7: rollover inside the window
    wait_lo(8'hFD);
    cyc(1, 0, A_LO, 0, 0, "R7"); idle(2, 0);
    cyc(1, 0, A_HI, 0, 0, "R7");
    expect_status(0, "R7");
    // R7: lower read on the rollover edge
    wait_lo(8'hFF);
    cyc(1, 0, A_LO, 0, 0, "R7");
    cyc(1, 0, A_HI, 0, 0, "R7");
    expect_status(0, "R7");
    // R7: upper read on the rollover edge stays clean
    wait_lo(8'hFE);
    cyc(1, 0, A_LO, 0, 0, "R7");
    cyc(1, 0, A_HI, 0, 0, "R7");
    expect_status(1, "R7");

    // R9: status holds across control, lower reads and interrupts
    cyc(1, 0, A_CTRL, 0, 1, "R9");
    idle(3, 1);
    cyc(1, 0, A_LO, 0, 0, "R9");
    expect_status(1, "R9");

    // R8: repeated upper read, and upper read with no lower read
    wait_lo(8'h40);
    cyc(1, 0, A_LO, 0, 0, "R8");
    cyc(1, 0, A_HI, 0, 0, "R8");
    cyc(1, 0, A_HI, 0, 0, "R8");
    expect_status(0, "R8");

    // R2: disable holds the count
    cyc(0, 1, A_CTRL, 32'h0, 0, "R2");
    cyc(1, 0, A_LO, 0, 0, "R2");
    idle(4, 0);
    cyc(1, 0, A_LO, 0, 0, "R2");
    cyc(1, 0, A_CTRL, 0, 0, "R2");
    cyc(0, 1, A_CTRL, 32'hFFFF_FFFF, 0, "R2");

    // R11: unmapped addresses
    cyc(1, 0, 12'h102, 0, 0, "R11");
    cyc(1, 0, 12'h106, 0, 0, "R11");
    cyc(1, 0, 12'h000, 0, 0, "R11");

    // mixed random traffic
    for (int i = 0; i < 6000; i++) begin
      int op;
      bit irq;
      op  = $urandom % 20;
      irq = ($urandom % 10) == 0;
      if (op < 6)       cyc(1, 0, A_LO, 0, irq, "R3");
      else if (op < 12) cyc(1, 0, A_HI, 0, irq, "R7");
      else if (op < 15) cyc(1, 0, A_CTRL, 0, irq, "R9");
      else if (op == 15) cyc(0, 1, A_CTRL, $urandom | 32'((($urandom % 4) != 0)), irq, "R2");
      else if (op == 16) cyc(0, 1, (($urandom % 2) != 0) ? A_LO : A_HI, $urandom, irq, "R4");
      else if (op == 17) cyc(1, 0, 12'h200 + 12'($urandom % 8), 0, irq, "R11");
      else              idle(1, irq);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule